// File: doc/BRIEF.md
# Floppy Subsystem Host Port Registers

This block is the host-side register set of a floppy disk subsystem controller sitting on an 8-bit I/O port bus. The host reads a packed status byte, a result-type byte and a result byte. It writes a two-byte parameter-block address, and the write of the high byte launches an operation. A separate port write reinitialises the controller state. The same eight-port register window also answers at a second alias window placed sixteen ports above the base.

On the other side sits a command engine. It reports completion with a result type, an error byte and a done strobe, and it signals when it is busy. The engine receives a one-cycle start strobe together with the latched 16-bit address. Four drive-ready inputs are sampled every cycle. They feed the status byte and a reordered ready map. Any change in them raises a ready-changed flag, which decides whether the result byte shows that map.

Top module: `fdc_host_regs`

## Requirements
- R1: During and right after synchronous reset the result type is 2'b10, the interrupt is low, the ready-changed flag is clear, no start strobe is given and the launch address is 16'h0000.
- R2: A read of offset 0 returns {1'b0, rdy3, rdy2, 1'b1, 1'b1, irq, rdy1, rdy0}. The rdyN values are the drive-ready inputs sampled at the previous clock edge.
- R3: A read of offset 1 returns the result type in bits 1:0 and zeros in bits 7:2, and clears the interrupt at the next edge. A completion in the same cycle wins, so the interrupt stays set.
- R4: A completion strobe captures the engine's result type and error byte and sets the interrupt at the next edge. The `irq` output and status bit 2 both follow it.
- R5: With result type 2'b00, a read of offset 3 returns the captured error byte (bit 7 not ready, bit 5 write protect, bit 3 address, bit 0 deleted record, and so on).
- R6: With result type 2'b10 and the ready-changed flag set, a read of offset 3 returns {rdy1, rdy0, rdy3, rdy2, 4'b0000}.
- R7: With result type 2'b10 and the flag clear, or with a reserved type (2'b01, 2'b11), a read of offset 3 returns 8'h00.
- R8: The ready-changed flag sets at the edge after the drive-ready inputs differ from their previous sample, and it stays set until reinitialisation.
- R9: A write to offset 1 latches the low address byte and a write to offset 2 latches the high byte. The offset-2 write raises `start_pulse` for exactly the following cycle, with `start_addr` = {high, low}.
- R10: An offset-2 write while `eng_busy` is high still latches the high byte but gives no start strobe.
- R11: A write to offset 7 sets the result type to 2'b10, clears the interrupt and the ready-changed flag, and resamples the drive-ready inputs. It takes priority over a completion in the same cycle.
- R12: The registers answer at base+0..7 and at base+16..23. Every other address reads 8'h00 and a write there changes nothing. Unused offsets inside a window also read 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 8 | Port address |
| io_rd | input | 1 | Port read strobe |
| io_wr | input | 1 | Port write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, 0 when no register is read |
| drv_rdy | input | 4 | Drive-ready inputs, bit N for drive N |
| eng_done | input | 1 | Engine completion strobe |
| eng_rtype | input | 2 | Result type given with completion |
| eng_err | input | 8 | Error byte given with completion |
| eng_busy | input | 1 | Engine busy, suppresses start |
| start_pulse | output | 1 | One-cycle launch strobe |
| start_addr | output | 16 | Latched parameter-block address |
| irq | output | 1 | Interrupt flip-flop, active high |

## Verification
Read data is combinational on the current address and registered state, so it is due in the same cycle as the read strobe. Register effects of writes, completions and ready changes become visible one edge later. The start strobe appears in the cycle after the high-byte write, and an interrupt clear is visible one cycle after the result-type read. The bench drives every input just after a falling edge and compares all outputs against its behavioural model just before the next rising edge. The model advances only after that edge, so each result is sampled in exactly the cycle it is due.

// File: rtl/fdc_pkg.sv
// Package: shared constants and the decoded-access type for the host
// port register set. Assumes an 8-port register window.
package fdc_pkg;
    localparam int unsigned OFF_W    = 3;
    localparam int unsigned WIN_SIZE = 1 << OFF_W;

    // register offsets inside a window
    localparam logic [OFF_W-1:0] OFF_STATUS = 3'd0;
    localparam logic [OFF_W-1:0] OFF_TYPE   = 3'd1; // read type / write low addr
    localparam logic [OFF_W-1:0] OFF_ADDRHI = 3'd2;
    localparam logic [OFF_W-1:0] OFF_RESULT = 3'd3;
    localparam logic [OFF_W-1:0] OFF_REINIT = 3'd7;

    // result type encodings
    localparam logic [1:0] RT_FAIL = 2'b00;
    localparam logic [1:0] RT_GOOD = 2'b10;

    // one-hot strobes after decode
    typedef struct packed {
        logic rd_status;
        logic rd_type;
        logic rd_result;
        logic wr_addrlo;
        logic wr_addrhi;
        logic wr_reinit;
    } acc_t;
endpackage

// File: rtl/fdc_port_decode.sv
// Module: address window decode. Matches N_WINDOWS windows of WIN_SIZE
// ports spaced ALIAS_STRIDE apart from BASE_ADDR and turns the bus strobes
// into per-register strobes. Assumes ALIAS_STRIDE >= WIN_SIZE (no overlap).
module fdc_port_decode
    import fdc_pkg::*;
#(
    parameter int unsigned AW           = 8,
    parameter int unsigned BASE_ADDR    = 8'h78,
    parameter int unsigned ALIAS_STRIDE = 16,
    parameter int unsigned N_WINDOWS    = 2
) (
    input  logic [AW-1:0] io_addr,
    input  logic          io_rd,
    input  logic          io_wr,
    output acc_t          acc
);
    logic [N_WINDOWS-1:0] win_hit;
    logic [OFF_W-1:0]     win_off [N_WINDOWS];
    logic                 hit;
    logic [OFF_W-1:0]     off;

    for (genvar w = 0; w < N_WINDOWS; w++) begin : g_win
        localparam int unsigned WB = BASE_ADDR + w * ALIAS_STRIDE;
        logic [AW-1:0] diff;
        // distance of the address from this window's base
        assign diff       = io_addr - AW'(WB);
        assign win_hit[w] = diff < AW'(WIN_SIZE);
        assign win_off[w] = win_hit[w] ? diff[OFF_W-1:0] : '0;
    end

    // merge the window matches into one hit and offset
    always_comb begin
        hit = |win_hit;
        off = '0;
        for (int w = 0; w < N_WINDOWS; w++) off = off | win_off[w];
    end

    // per-register strobes
    always_comb begin
        acc           = '0;
        acc.rd_status = hit && io_rd && (off == OFF_STATUS);
        acc.rd_type   = hit && io_rd && (off == OFF_TYPE);
        acc.rd_result = hit && io_rd && (off == OFF_RESULT);
        acc.wr_addrlo = hit && io_wr && (off == OFF_TYPE);
        acc.wr_addrhi = hit && io_wr && (off == OFF_ADDRHI);
        acc.wr_reinit = hit && io_wr && (off == OFF_REINIT);
    end
endmodule

// File: rtl/fdc_result_unit.sv
// Module: completion state. Holds the result type, error byte, interrupt
// flip-flop, sampled drive-ready bits and the ready-changed flag.
// Assumes at most one completion strobe per cycle; reinit outranks it.
module fdc_result_unit
    import fdc_pkg::*;
#(
    parameter int unsigned N_DRV = 4,
    parameter int unsigned DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_type,
    input  logic             wr_reinit,
    input  logic             eng_done,
    input  logic [1:0]       eng_rtype,
    input  logic [DW-1:0]    eng_err,
    input  logic [N_DRV-1:0] drv_rdy,
    output logic [1:0]       rtype,
    output logic [DW-1:0]    err_byte,
    output logic             irq_ff,
    output logic             rdy_chg,
    output logic [N_DRV-1:0] rdy_q
);
    // drive-ready sample, refreshed every cycle including reset and reinit
    always_ff @(posedge clk) rdy_q <= drv_rdy;

    // ready-changed flag: set on any difference, cleared by reset/reinit
    always_ff @(posedge clk) begin
        if (!rst_n || wr_reinit)   rdy_chg <= 1'b0;
        else if (drv_rdy != rdy_q) rdy_chg <= 1'b1;
    end

    // result type and error byte capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rtype    <= RT_GOOD;
            err_byte <= '0;
        end else if (wr_reinit) begin
            rtype    <= RT_GOOD;
        end else if (eng_done) begin
            rtype    <= eng_rtype;
            err_byte <= eng_err;
        end
    end

    // interrupt flip-flop: set by completion, cleared by type read
    always_ff @(posedge clk) begin
        if (!rst_n || wr_reinit) irq_ff <= 1'b0;
        else if (eng_done)       irq_ff <= 1'b1;
        else if (rd_type)        irq_ff <= 1'b0;
    end
endmodule

// File: rtl/fdc_launch.sv
// Module: parameter-block address latch and start strobe. The strobe is
// registered, so it follows the high-byte write by one cycle. Assumes the
// engine samples start_addr during the strobe cycle.
module fdc_launch #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    input  logic          eng_busy,
    output logic          start_pulse,
    output logic [2*DW-1:0] start_addr
);
    logic [DW-1:0] lo_q, hi_q;

    // address byte latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) hi_q <= wdata;
        end
    end

    // start strobe, withheld while the engine is busy
    always_ff @(posedge clk) begin
        if (!rst_n) start_pulse <= 1'b0;
        else        start_pulse <= wr_hi && !eng_busy;
    end

    assign start_addr = {hi_q, lo_q};
endmodule

// File: rtl/fdc_host_regs.sv
// Module: top of the host port register set. Decodes the port windows,
// holds completion and launch state, and builds the read data.
// Assumes io_rd and io_wr are single-cycle strobes from the bus logic.
module fdc_host_regs
    import fdc_pkg::*;
#(
    parameter int unsigned AW           = 8,
    parameter int unsigned DW           = 8,
    parameter int unsigned BASE_ADDR    = 8'h78,
    parameter int unsigned ALIAS_STRIDE = 16,
    parameter int unsigned N_WINDOWS    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   io_addr,
    input  logic            io_rd,
    input  logic            io_wr,
    input  logic [DW-1:0]   io_wdata,
    output logic [DW-1:0]   io_rdata,
    input  logic [3:0]      drv_rdy,
    input  logic            eng_done,
    input  logic [1:0]      eng_rtype,
    input  logic [DW-1:0]   eng_err,
    input  logic            eng_busy,
    output logic            start_pulse,
    output logic [2*DW-1:0] start_addr,
    output logic            irq
);
    localparam int unsigned N_DRV = 4;

    acc_t             acc;
    logic [1:0]       rtype;
    logic [DW-1:0]    err_byte;
    logic             irq_ff;
    logic             rdy_chg;
    logic [N_DRV-1:0] rdy_q;

    fdc_port_decode #(
        .AW(AW), .BASE_ADDR(BASE_ADDR),
        .ALIAS_STRIDE(ALIAS_STRIDE), .N_WINDOWS(N_WINDOWS)
    ) dec_i (
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .acc(acc)
    );

    fdc_result_unit #(.N_DRV(N_DRV), .DW(DW)) res_i (
        .clk(clk), .rst_n(rst_n),
        .rd_type(acc.rd_type), .wr_reinit(acc.wr_reinit),
        .eng_done(eng_done), .eng_rtype(eng_rtype), .eng_err(eng_err),
        .drv_rdy(drv_rdy),
        .rtype(rtype), .err_byte(err_byte), .irq_ff(irq_ff),
        .rdy_chg(rdy_chg), .rdy_q(rdy_q)
    );

    fdc_launch #(.DW(DW)) lau_i (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(acc.wr_addrlo), .wr_hi(acc.wr_addrhi), .wdata(io_wdata),
        .eng_busy(eng_busy),
        .start_pulse(start_pulse), .start_addr(start_addr)
    );

    assign irq = irq_ff;

    // read data: status, type, or context-dependent result byte
    always_comb begin
        io_rdata = '0;
        if (acc.rd_status) begin
            io_rdata = DW'({1'b0, rdy_q[3], rdy_q[2], 1'b1, 1'b1,
                            irq_ff, rdy_q[1], rdy_q[0]});
        end else if (acc.rd_type) begin
            io_rdata = DW'(rtype);
        end else if (acc.rd_result) begin
            if (rtype == RT_FAIL)
                io_rdata = err_byte;
            else if (rtype == RT_GOOD && rdy_chg)
                io_rdata = DW'({rdy_q[1], rdy_q[0], rdy_q[3], rdy_q[2], 4'b0000});
        end
    end
endmodule

// File: rtl/fdc_host_regs_chk.sv
// Module: assertion checker bound to the top. Observes ports only and
// decodes the two window addresses of the relevant offsets itself.
module fdc_host_regs_chk #(
    parameter int unsigned BASE_ADDR    = 8'h78,
    parameter int unsigned ALIAS_STRIDE = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  io_addr,
    input logic        io_rd,
    input logic        io_wr,
    input logic [7:0]  io_rdata,
    input logic        eng_done,
    input logic        eng_busy,
    input logic        start_pulse,
    input logic        irq
);
    localparam logic [7:0] A0 = 8'(BASE_ADDR);
    localparam logic [7:0] B0 = 8'(BASE_ADDR + ALIAS_STRIDE);

    logic at0, at1, at2, at7;
    assign at0 = (io_addr == A0)            || (io_addr == B0);
    assign at1 = (io_addr == A0 + 8'd1)     || (io_addr == B0 + 8'd1);
    assign at2 = (io_addr == A0 + 8'd2)     || (io_addr == B0 + 8'd2);
    assign at7 = (io_addr == A0 + 8'd7)     || (io_addr == B0 + 8'd7);

    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(io_wr && at2 && !eng_busy)); // R9
    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at2 && eng_busy) |=> !start_pulse); // R10
    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !(io_wr && at7)) |=> irq); // R4
    AST_REINIT_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at7) |=> !irq); // R11
    AST_TYPE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at1 && !eng_done && !(io_wr && at7)) |=> !irq); // R3
    AST_TYPE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at1) |-> (io_rdata[7:2] == 6'd0)); // R3
    AST_STATUS_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at0) |-> (io_rdata[4:3] == 2'b11 && !io_rdata[7])); // R2
endmodule

bind fdc_host_regs fdc_host_regs_chk #(
    .BASE_ADDR(BASE_ADDR), .ALIAS_STRIDE(ALIAS_STRIDE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .io_wr(io_wr), .io_rdata(io_rdata), .eng_done(eng_done),
    .eng_busy(eng_busy), .start_pulse(start_pulse), .irq(irq)
);

// File: tb/fdc_host_regs_tb_top.sv
// Bench: behavioural reference model advanced per clock; every output is
// compared each cycle just before the rising edge.
module fdc_host_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  io_addr, io_wdata, eng_err;
    logic        io_rd, io_wr, eng_done, eng_busy;
    logic [1:0]  eng_rtype;
    logic [3:0]  drv_rdy;
    logic [7:0]  io_rdata;
    logic        start_pulse, irq;
    logic [15:0] start_addr;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit chk_en = 0;

    // model state
    int m_rtype, m_err, m_irq, m_chg, m_rdy, m_lo, m_hi, m_start;

    fdc_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .drv_rdy(drv_rdy), .eng_done(eng_done), .eng_rtype(eng_rtype),
        .eng_err(eng_err), .eng_busy(eng_busy), .start_pulse(start_pulse),
        .start_addr(start_addr), .irq(irq)
    );

    always #10 clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int win_off(int a);
        if (a >= 'h78 && a <= 'h7F) return a - 'h78;
        if (a >= 'h88 && a <= 'h8F) return a - 'h88;
        return -1;
    endfunction

    function automatic int rbit(int n);
        return (m_rdy >> n) & 1;
    endfunction

    function automatic int exp_rdata(int a, bit rd);
        int o = win_off(a);
        if (!rd) return 0;
        case (o)
            0: return (rbit(3) << 6) | (rbit(2) << 5) | 'h18 | (m_irq << 2)
                      | (rbit(1) << 1) | rbit(0);
            1: return m_rtype;
            3: begin
                if (m_rtype == 0) return m_err;
                if (m_rtype == 2 && m_chg != 0)
                    return (rbit(1) << 7) | (rbit(0) << 6) | (rbit(3) << 5) | (rbit(2) << 4);
                return 0;
            end
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive, compare before edge, then advance model
    task automatic step(string tag, int a, bit rd, bit wr, int d,
                        bit done, int rt, int er, bit busy, int rdy);
        int o = win_off(a);
        io_addr = 8'(a); io_rd = rd; io_wr = wr; io_wdata = 8'(d);
        eng_done = done; eng_rtype = 2'(rt); eng_err = 8'(er);
        eng_busy = busy; drv_rdy = 4'(rdy);
        #5;
        if (chk_en) begin
            check(tag, "rdata", int'(io_rdata), exp_rdata(a, rd));
            check(tag, "irq", int'(irq), m_irq);
            check(tag, "start", int'(start_pulse), m_start);
            if (m_start != 0)
                check(tag, "addr", int'(start_addr), (m_hi << 8) | m_lo);
        end
        @(posedge clk); #1;
        if (!rst_n) begin
            m_rtype = 2; m_err = 0; m_irq = 0; m_chg = 0;
            m_lo = 0; m_hi = 0; m_start = 0;
        end else begin
            bit reinit = wr && o == 7;
            m_chg   = reinit ? 0 : ((rdy != m_rdy) ? 1 : m_chg);
            if (reinit) m_rtype = 2;
            else if (done) begin m_rtype = rt; m_err = er; end
            m_irq   = reinit ? 0 : done ? 1 : (rd && o == 1) ? 0 : m_irq;
            m_start = (wr && o == 2 && !busy) ? 1 : 0;
            if (wr && o == 1) m_lo = d;
            if (wr && o == 2) m_hi = d;
        end
        m_rdy = rdy;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        m_rdy = 0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 'b0101);
        rst_n = 1'b1;
        chk_en = 1;
        // R1 reset state, R2 status layout
        step("R1", 'h79, 1, 0, 0, 0, 0, 0, 0, 'b0101);
        step("R2", 'h78, 1, 0, 0, 0, 0, 0, 0, 'b0101);
        step("R7", 'h7B, 1, 0, 0, 0, 0, 0, 0, 'b0101);
        // R8 ready change then R6 map
        step("R8", 'h78, 1, 0, 0, 0, 0, 0, 0, 'b1110);
        step("R6", 'h7B, 1, 0, 0, 0, 0, 0, 0, 'b1110);
        step("R2", 'h78, 1, 0, 0, 0, 0, 0, 0, 'b1110);
        // R4 completion with error, R5 error byte
        step("R4", 'h00, 0, 0, 0, 1, 0, 'hA5, 0, 'b1110);
        step("R4", 'h78, 1, 0, 0, 0, 0, 0, 0, 'b1110);
        step("R5", 'h7B, 1, 0, 0, 0, 0, 0, 0, 'b1110);
        step("R3", 'h79, 1, 0, 0, 0, 0, 0, 0, 'b1110);
        step("R3", 'h78, 1, 0, 0, 0, 0, 0, 0, 'b1110);
        // R7 reserved type reads zero
        step("R7", 'h00, 0, 0, 0, 1, 1, 'h3C, 0, 'b1110);
        step("R7", 'h7B, 1, 0, 0, 0, 0, 0, 0, 'b1110);
        step("R7", 'h00, 0, 0, 0, 1, 3, 'h11, 0, 'b1110);
        step("R7", 'h7B, 1, 0, 0, 0, 0, 0, 0, 'b1110);
        // R3 completion during type read keeps irq
        step("R3", 'h79, 1, 0, 0, 1, 2, 0, 0, 'b1110);
        step("R3", 'h79, 1, 0, 0, 0, 0, 0, 0, 'b1110);
        step("R3", 'h78, 1, 0, 0, 0, 0, 0, 0, 'b1110);
        // R9 launch
        step("R9", 'h79, 0, 1, 'h34, 0, 0, 0, 0, 'b1110);
        step("R9", 'h7A, 0, 1, 'h12, 0, 0, 0, 0, 'b1110);
        step("R9", 'h00, 0, 0, 0, 0, 0, 0, 0, 'b1110);
        step("R9", 'h00, 0, 0, 0, 0, 0, 0, 0, 'b1110);
        // R12 alias window launch
        step("R12", 'h89, 0, 1, 'hCD, 0, 0, 0, 0, 'b1110);
        step("R12", 'h8A, 0, 1, 'hAB, 0, 0, 0, 0, 'b1110);
        step("R12", 'h88, 1, 0, 0, 0, 0, 0, 0, 'b1110);
        // R10 busy suppresses start, high byte still latched
        step("R10", 'h7A, 0, 1, 'h56, 0, 0, 0, 1, 'b1110);
        step("R10", 'h00, 0, 0, 0, 0, 0, 0, 0, 'b1110);
        step("R10", 'h7A, 0, 1, 'h77, 0, 0, 0, 0, 'b1110);
        step("R10", 'h00, 0, 0, 0, 0, 0, 0, 0, 'b1110);
        // R11 reinit beats a completion
        step("R11", 'h00, 0, 0, 0, 1, 0, 'h80, 0, 'b0011);
        step("R11", 'h7F, 0, 1, 0, 1, 0, 'h20, 0, 'b0011);
        step("R11", 'h79, 1, 0, 0, 0, 0, 0, 0, 'b0011);
        step("R11", 'h7B, 1, 0, 0, 0, 0, 0, 0, 'b0011);
        step("R11", 'h78, 1, 0, 0, 0, 0, 0, 0, 'b0011);
        // R12 outside addresses and unused offsets
        step("R12", 'h80, 0, 1, 'h99, 0, 0, 0, 0, 'b0011);
        step("R12", 'h80, 1, 0, 0, 0, 0, 0, 0, 'b0011);
        step("R12", 'h7C, 1, 0, 0, 0, 0, 0, 0, 'b0011);
        step("R12", 'h98, 1, 0, 0, 0, 0, 0, 0, 'b0011);
        step("R12", 'h8F, 0, 1, 0, 0, 0, 0, 0, 'b0011);
        step("R12", 'h8B, 1, 0, 0, 0, 0, 0, 0, 'b0011);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int pick = int'($urandom_range(0, 11));
            int a = (pick < 5) ? ('h78 + pick) : (pick < 10) ? ('h88 + pick - 5)
                  : (pick == 10) ? 'h7F : 'h60;
            bit wr = $urandom_range(0, 3) == 0;
            bit rd = !wr && ($urandom_range(0, 1) == 1);
            step("mixed", a, rd, wr, int'($urandom_range(0, 255)),
                 $urandom_range(0, 4) == 0, int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 255)), $urandom_range(0, 3) == 0,
                 ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 15)) : m_rdy);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule